// File: doc/BRIEF.md
# Data Flash Erase and Program Controller

This block sits on a small register bus and drives a self-contained byte-wide data flash array. It can erase an aligned block, erase an aligned sector, or program one byte. Once started, an operation runs in the background, so the host keeps issuing bus cycles. The host can poll a status register, which reads zero when idle. It can also take a latched completion interrupt.

A command is accepted only when several gates are satisfied. The host must first raise a self-programming enable. It must then write a two-byte key in order and select the data segment. Any command attempt, accepted or not, uses up the key. A rejected attempt leaves the array untouched and sets a sticky error flag. Erase writes 0xFF over the whole aligned range. Programming ANDs the supplied byte into the addressed cell. While an operation runs, reads of the array return zero instead of array contents.

Top module: `dflash_ctl`

## Requirements
- R1: After reset the status register (offset 0x7) reads 0x00, the error register (0x8) reads 0x00, the interrupt flag (0xA) reads 0x00, `irq` is low, and every array byte read through the data port (0xC) is 0xFF.
- R2: A command starts only if all of the following hold. Bit 0 of the enable register (0x0) is 1. The key register (0x1) has received 0xFA and then 0xF5 while enabled. The segment register (0x2) holds 0x1F. No operation is running.
- R3: The key returns to locked in each of these cases: a key byte other than the expected one is written, 0xF5 is written without a preceding 0xFA, or the enable bit is cleared. A later command is then rejected.
- R4: Any write to the command register (0x5) with a non-zero command consumes the unlock. A second command needs the key written again.
- R5: A command issued with a segment value other than 0x1F leaves the array unchanged and sets bit 0 of the error register. The error register is cleared by any write to offset 0x8.
- R6: A block erase (command bit 2) sets to 0xFF every byte of the BLK_BYTES-aligned block (default 2048) that holds the address (offsets 0x3 low byte, 0x4 high byte). Bytes outside that block are not changed.
- R7: A sector erase (command bit 1) sets to 0xFF every byte of the SECT_BYTES-aligned sector (default 128) that holds the address. Bytes outside that sector are not changed.
- R8: A program command (command bit 0) stores the write-data byte (offset 0x6) ANDed with the byte already held at the address.
- R9: The status register reads 0x01 for exactly T_PROG, T_SECT or T_BLK cycles after the accepting write (defaults 5, 140, 2060), and reads 0x00 otherwise. A command issued while busy is ignored and sets the error flag.
- R10: While an operation runs, the data port reads 0x00 whatever the addressed contents.
- R11: If bit 0 of the interrupt-enable register (0x9) is 1 when an operation ends, the interrupt flag (0xA bit 0) and `irq` go high and stay high until bit 0 of 0xB is written as 1. With the enable at 0, completion leaves the flag low.
- R12: When several command bits are set, block erase wins over sector erase, and sector erase wins over program. A command write of 0x00 starts nothing, flags no error and keeps the unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset for reads and writes |
| bus_wr | input | 1 | Write strobe, registered at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the register at `bus_addr`, combinational |
| irq | output | 1 | Latched completion interrupt |

## Verification
Some properties are checked by assertions on every cycle. The array is written only during an operation. The data port is blind while busy. An operation can start only from the unlocked state, with the data segment selected, and it leaves the key locked. An enabled completion always raises `irq`. The bench scenarios are needed for the rest: the aligned extents of both erase sizes, the AND behaviour of programming, the exact busy durations, every way of re-locking the key, and command priority. Those depend on array contents and cycle counts that a single-cycle property cannot see.

// File: rtl/df_pkg.sv
package df_pkg;

    // register offsets on the host bus
    localparam logic [3:0] RG_ENA  = 4'h0;
    localparam logic [3:0] RG_KEY  = 4'h1;
    localparam logic [3:0] RG_SEG  = 4'h2;
    localparam logic [3:0] RG_ADRL = 4'h3;
    localparam logic [3:0] RG_ADRH = 4'h4;
    localparam logic [3:0] RG_CMD  = 4'h5;
    localparam logic [3:0] RG_WDAT = 4'h6;
    localparam logic [3:0] RG_STAT = 4'h7;
    localparam logic [3:0] RG_ERR  = 4'h8;
    localparam logic [3:0] RG_IEN  = 4'h9;
    localparam logic [3:0] RG_IFLG = 4'hA;
    localparam logic [3:0] RG_ICLR = 4'hB;
    localparam logic [3:0] RG_DATA = 4'hC;

    localparam logic [7:0] KEY_FIRST  = 8'hFA;
    localparam logic [7:0] KEY_SECOND = 8'hF5;
    localparam logic [7:0] SEG_DFLASH = 8'h1F;

    typedef enum logic [1:0] {LK_SHUT, LK_HALF, LK_OPEN} lock_e;
    typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_SECT, OP_BLK} op_e;

    // block erase beats sector erase beats program
    function automatic op_e decode_cmd(input logic [7:0] c);
        if (c[2])      return OP_BLK;
        else if (c[1]) return OP_SECT;
        else if (c[0]) return OP_PROG;
        else           return OP_NONE;
    endfunction

endpackage

// File: rtl/df_unlock.sv
module df_unlock
    import df_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ena_i,
    input  logic       key_wr_i,
    input  logic [7:0] key_i,
    input  logic       consume_i,
    output logic       open_o
);
    lock_e st_q;

    always_ff @(posedge clk) begin
        if (rst || !ena_i) begin
            st_q <= LK_SHUT;
        end else if (consume_i) begin
            st_q <= LK_SHUT;
        end else if (key_wr_i) begin
            if (key_i == KEY_FIRST)
                st_q <= LK_HALF;
            else if (key_i == KEY_SECOND && st_q == LK_HALF)
                st_q <= LK_OPEN;
            else
                st_q <= LK_SHUT;
        end
    end

    assign open_o = (st_q == LK_OPEN);
endmodule

// File: rtl/df_array.sv
module df_array #(
    parameter int DEPTH = 4096,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_i,
    input  logic          and_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (we_i) begin
            mem_q[waddr_i] <= and_i ? (mem_q[waddr_i] & wdata_i) : wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/df_engine.sv
module df_engine
    import df_pkg::*;
#(
    parameter int AW         = 12,
    parameter int SECT_BYTES = 128,
    parameter int BLK_BYTES  = 2048,
    parameter int T_PROG     = 5,
    parameter int T_SECT     = 140,
    parameter int T_BLK      = 2060
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  op_e           kind_i,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    data_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          we_o,
    output logic          and_o,
    output logic [AW-1:0] waddr_o,
    output logic [7:0]    wdata_o
);
    localparam int T_MAX = (T_BLK > T_SECT) ? ((T_BLK > T_PROG) ? T_BLK : T_PROG)
                                            : ((T_SECT > T_PROG) ? T_SECT : T_PROG);
    localparam int CW = $clog2(T_MAX + 1) + 1;
    localparam logic [AW-1:0] SMASK = AW'(SECT_BYTES - 1);
    localparam logic [AW-1:0] BMASK = AW'(BLK_BYTES - 1);

    logic          busy_q;
    op_e           kind_q;
    logic [AW-1:0] base_q;
    logic [7:0]    data_q;
    logic [CW-1:0] cnt_q;

    logic [CW-1:0] dur, span;
    logic          last, sweep;

    always_comb begin
        case (kind_q)
            OP_SECT: begin dur = CW'(T_SECT); span = CW'(SECT_BYTES); end
            OP_BLK:  begin dur = CW'(T_BLK);  span = CW'(BLK_BYTES);  end
            default: begin dur = CW'(T_PROG); span = '0;              end
        endcase
    end

    assign last  = busy_q && (cnt_q == dur - CW'(1));
    assign sweep = busy_q && (kind_q == OP_SECT || kind_q == OP_BLK) && (cnt_q < span);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            kind_q <= OP_NONE;
            base_q <= '0;
            data_q <= '0;
            cnt_q  <= '0;
        end else if (start_i && !busy_q) begin
            busy_q <= 1'b1;
            kind_q <= kind_i;
            data_q <= data_i;
            cnt_q  <= '0;
            case (kind_i)
                OP_SECT: base_q <= addr_i & ~SMASK;
                OP_BLK:  base_q <= addr_i & ~BMASK;
                default: base_q <= addr_i;
            endcase
        end else if (busy_q) begin
            if (last) busy_q <= 1'b0;
            else      cnt_q  <= cnt_q + CW'(1);
        end
    end

    assign busy_o  = busy_q;
    assign done_o  = last;
    assign we_o    = sweep || (last && kind_q == OP_PROG);
    assign and_o   = !sweep;
    assign waddr_o = sweep ? (base_q | AW'(cnt_q)) : base_q;
    assign wdata_o = sweep ? 8'hFF : data_q;
endmodule

// File: rtl/dflash_ctl.sv
module dflash_ctl
    import df_pkg::*;
#(
    parameter int DF_BYTES   = 4096,
    parameter int SECT_BYTES = 128,
    parameter int BLK_BYTES  = 2048,
    parameter int T_PROG     = 5,
    parameter int T_SECT     = 140,
    parameter int T_BLK      = 2060
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq
);
    localparam int AW = $clog2(DF_BYTES);

    logic          ena_q, ien_q, iflg_q, err_q;
    logic [7:0]    seg_q, adrl_q, adrh_q, wdat_q;
    logic [15:0]   adr_full;
    logic [AW-1:0] adr;

    logic          open, busy, done;
    logic          mem_we, mem_and;
    logic [AW-1:0] mem_waddr;
    logic [7:0]    mem_wdata, mem_rdata;

    op_e  cmd_kind;
    logic cmd_wr, cmd_any, start, reject;

    assign adr_full = {adrh_q, adrl_q};
    assign adr      = adr_full[AW-1:0];

    assign cmd_wr   = bus_wr && (bus_addr == RG_CMD);
    assign cmd_kind = decode_cmd(bus_wdata);
    assign cmd_any  = cmd_wr && (cmd_kind != OP_NONE);
    assign start    = cmd_any && ena_q && open && (seg_q == SEG_DFLASH) && !busy;
    assign reject   = cmd_any && !start;

    df_unlock u_lock (
        .clk       (clk),
        .rst       (rst),
        .ena_i     (ena_q),
        .key_wr_i  (bus_wr && bus_addr == RG_KEY),
        .key_i     (bus_wdata),
        .consume_i (cmd_any),
        .open_o    (open)
    );

    df_engine #(
        .AW(AW), .SECT_BYTES(SECT_BYTES), .BLK_BYTES(BLK_BYTES),
        .T_PROG(T_PROG), .T_SECT(T_SECT), .T_BLK(T_BLK)
    ) u_eng (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .kind_i  (cmd_kind),
        .addr_i  (adr),
        .data_i  (wdat_q),
        .busy_o  (busy),
        .done_o  (done),
        .we_o    (mem_we),
        .and_o   (mem_and),
        .waddr_o (mem_waddr),
        .wdata_o (mem_wdata)
    );

    df_array #(.DEPTH(DF_BYTES)) u_arr (
        .clk     (clk),
        .rst     (rst),
        .we_i    (mem_we),
        .and_i   (mem_and),
        .waddr_i (mem_waddr),
        .wdata_i (mem_wdata),
        .raddr_i (adr),
        .rdata_o (mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ena_q  <= 1'b0;
            ien_q  <= 1'b0;
            seg_q  <= '0;
            adrl_q <= '0;
            adrh_q <= '0;
            wdat_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                RG_ENA:  ena_q  <= bus_wdata[0];
                RG_SEG:  seg_q  <= bus_wdata;
                RG_ADRL: adrl_q <= bus_wdata;
                RG_ADRH: adrh_q <= bus_wdata;
                RG_WDAT: wdat_q <= bus_wdata;
                RG_IEN:  ien_q  <= bus_wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q  <= 1'b0;
            iflg_q <= 1'b0;
        end else begin
            if (reject)                                err_q <= 1'b1;
            else if (bus_wr && bus_addr == RG_ERR)     err_q <= 1'b0;
            if (done && ien_q)                         iflg_q <= 1'b1;
            else if (bus_wr && bus_addr == RG_ICLR && bus_wdata[0]) iflg_q <= 1'b0;
        end
    end

    always_comb begin
        case (bus_addr)
            RG_ENA:  bus_rdata = {7'd0, ena_q};
            RG_SEG:  bus_rdata = seg_q;
            RG_ADRL: bus_rdata = adrl_q;
            RG_ADRH: bus_rdata = adrh_q;
            RG_WDAT: bus_rdata = wdat_q;
            RG_STAT: bus_rdata = {7'd0, busy};
            RG_ERR:  bus_rdata = {7'd0, err_q};
            RG_IEN:  bus_rdata = {7'd0, ien_q};
            RG_IFLG: bus_rdata = {7'd0, iflg_q};
            RG_DATA: bus_rdata = busy ? 8'h00 : mem_rdata;
            default: bus_rdata = 8'h00;
        endcase
    end

    assign irq = iflg_q;
endmodule

// File: rtl/dflash_ctl_chk.sv
module dflash_ctl_chk
    import df_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [3:0] bus_addr,
    input logic [7:0] bus_rdata,
    input logic       irq,
    input logic       busy,
    input logic       open,
    input logic       mem_we,
    input logic       ien_q,
    input logic [7:0] seg_q
);
    p_we_in_op_r6: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    p_read_blocked_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_addr == RG_DATA) |-> (bus_rdata == 8'h00));

    p_start_unlocked_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(open));

    p_unlock_consumed_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !open);

    p_seg_match_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(seg_q) == SEG_DFLASH));

    p_irq_on_done_r11: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && $past(ien_q)) |-> irq);
endmodule

bind dflash_ctl dflash_ctl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .busy      (busy),
    .open      (open),
    .mem_we    (mem_we),
    .ien_q     (ien_q),
    .seg_q     (seg_q)
);

// File: tb/dflash_ctl_tb_top.sv
module dflash_ctl_tb_top;
    localparam int TP = 5, TS = 140, TB = 2060;
    localparam logic [3:0] A_ENA = 4'h0, A_KEY = 4'h1, A_SEG = 4'h2, A_ADRL = 4'h3,
                           A_ADRH = 4'h4, A_CMD = 4'h5, A_WDAT = 4'h6, A_STAT = 4'h7,
                           A_ERR = 4'h8, A_IEN = 4'h9, A_IFLG = 4'hA, A_ICLR = 4'hB,
                           A_DATA = 4'hC;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_chk = 0, n_bad = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;
    sb_item_t sb_q[$];
    event     mon_ev;

    always #10 clk = ~clk;   // 50 MHz

    dflash_ctl #(.T_PROG(TP), .T_SECT(TS), .T_BLK(TB)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic report(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected reads and compares against the bus
    always @(mon_ev) begin
        while (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            report(bus_rdata == it.exp, it.tag, bus_rdata, it.exp);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        sb_item_t it;
        @(negedge clk);
        bus_addr = a;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        #5;
        -> mon_ev;
    endtask

    task automatic set_adr(input logic [15:0] a);
        wr(A_ADRL, a[7:0]);
        wr(A_ADRH, a[15:8]);
    endtask

    task automatic rd_mem(input logic [15:0] a, input logic [7:0] e, input string tag);
        set_adr(a);
        rd(A_DATA, e, tag);
    endtask

    task automatic unlock();
        wr(A_KEY, 8'hFA);
        wr(A_KEY, 8'hF5);
    endtask

    // counts busy cycles starting right after the accepting write
    task automatic busy_len(output int n);
        bus_addr = A_STAT;
        #1;
        n = 0;
        while (bus_rdata[0]) begin
            n++;
            @(negedge clk);
            bus_addr = A_STAT;
            #1;
        end
    endtask

    task automatic do_cmd(input logic [15:0] a, input logic [7:0] d, input logic [7:0] c,
                          output int n);
        set_adr(a);
        wr(A_WDAT, d);
        unlock();
        wr(A_CMD, c);
        busy_len(n);
    endtask

    task automatic clr_err();
        wr(A_ERR, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_STAT, 8'h00, "R1 status");
        rd(A_ERR,  8'h00, "R1 error");
        rd(A_IFLG, 8'h00, "R1 flag");
        report(irq == 1'b0, "R1 irq pin", irq, 0);
        rd_mem(16'h000, 8'hFF, "R1 array low");
        rd_mem(16'hFFF, 8'hFF, "R1 array high");

        // R2 locked command is rejected
        wr(A_ENA, 8'h01);
        wr(A_SEG, 8'h1F);
        set_adr(16'h010);
        wr(A_WDAT, 8'h5A);
        wr(A_CMD, 8'h01);
        rd(A_STAT, 8'h00, "R2 no start when locked");
        rd(A_ERR,  8'h01, "R2 locked error");
        rd_mem(16'h010, 8'hFF, "R2 array untouched");
        clr_err();
        rd(A_ERR, 8'h00, "R5 error clear");

        // R2 R8 R9 program with proper unlock
        do_cmd(16'h010, 8'hA5, 8'h01, n);
        report(n == TP, "R9 program duration", n, TP);
        rd_mem(16'h010, 8'hA5, "R8 program value");
        rd(A_ERR, 8'h00, "R2 no error on accepted");

        // R4 second command without key
        wr(A_WDAT, 8'h00);
        wr(A_CMD, 8'h01);
        rd(A_ERR, 8'h01, "R4 unlock consumed");
        rd_mem(16'h010, 8'hA5, "R4 array untouched");
        clr_err();

        // R8 AND into existing contents
        do_cmd(16'h010, 8'h0F, 8'h01, n);
        rd_mem(16'h010, 8'h05, "R8 program AND");

        // R3 wrong order
        wr(A_KEY, 8'hF5); wr(A_KEY, 8'hFA);
        wr(A_CMD, 8'h01);
        rd(A_ERR, 8'h01, "R3 out of order key");
        clr_err();
        // R3 wrong byte
        wr(A_KEY, 8'hFA); wr(A_KEY, 8'h00); wr(A_KEY, 8'hF5);
        wr(A_CMD, 8'h01);
        rd(A_ERR, 8'h01, "R3 wrong key byte");
        clr_err();
        // R3 enable cleared
        unlock();
        wr(A_ENA, 8'h00); wr(A_ENA, 8'h01);
        wr(A_CMD, 8'h01);
        rd(A_ERR, 8'h01, "R3 enable cleared");
        clr_err();
        rd_mem(16'h010, 8'h05, "R3 array untouched");

        // R5 wrong segment
        wr(A_SEG, 8'h1E);
        unlock();
        wr(A_WDAT, 8'h00);
        wr(A_CMD, 8'h01);
        rd(A_STAT, 8'h00, "R5 no start");
        rd(A_ERR, 8'h01, "R5 segment error");
        rd_mem(16'h010, 8'h05, "R5 array untouched");
        clr_err();
        wr(A_SEG, 8'h1F);

        // preload around sector 0x100..0x17F
        do_cmd(16'h100, 8'h11, 8'h01, n);
        do_cmd(16'h17F, 8'h22, 8'h01, n);
        do_cmd(16'h180, 8'h33, 8'h01, n);
        do_cmd(16'h0FF, 8'h44, 8'h01, n);

        // R7 R9 R11 sector erase with interrupt
        wr(A_IEN, 8'h01);
        do_cmd(16'h140, 8'h00, 8'h02, n);
        report(n == TS, "R9 sector duration", n, TS);
        rd_mem(16'h100, 8'hFF, "R7 sector first");
        rd_mem(16'h17F, 8'hFF, "R7 sector last");
        rd_mem(16'h180, 8'h33, "R7 after sector");
        rd_mem(16'h0FF, 8'h44, "R7 before sector");
        rd(A_IFLG, 8'h01, "R11 flag set");
        report(irq == 1'b1, "R11 irq high", irq, 1);
        wr(A_ICLR, 8'h01);
        rd(A_IFLG, 8'h00, "R11 flag cleared");
        report(irq == 1'b0, "R11 irq low", irq, 0);
        wr(A_IEN, 8'h00);

        // preload across block boundary
        do_cmd(16'h7FF, 8'h12, 8'h01, n);
        do_cmd(16'h800, 8'h34, 8'h01, n);

        // R6 R9 R10 block erase; busy read and command rejection
        set_adr(16'h123);
        unlock();
        wr(A_CMD, 8'h04);
        set_adr(16'h800);
        rd(A_DATA, 8'h00, "R10 read blocked while busy");
        rd(A_STAT, 8'h01, "R9 status busy");
        unlock();
        wr(A_WDAT, 8'h00);
        wr(A_CMD, 8'h01);
        rd(A_ERR, 8'h01, "R9 busy command rejected");
        busy_len(n);
        clr_err();
        rd_mem(16'h000, 8'hFF, "R6 block start");
        rd_mem(16'h010, 8'hFF, "R6 block inner");
        rd_mem(16'h7FF, 8'hFF, "R6 block end");
        rd_mem(16'h800, 8'h34, "R6 next block untouched");
        rd(A_IFLG, 8'h00, "R11 flag stays low when disabled");

        // R9 block duration measured from the start
        do_cmd(16'h900, 8'h00, 8'h04, n);
        report(n == TB, "R9 block duration", n, TB);
        rd_mem(16'h800, 8'hFF, "R6 second block");

        // R12 priority: sector over program
        do_cmd(16'h880, 8'h00, 8'h01, n);
        rd_mem(16'h880, 8'h00, "R12 preload");
        do_cmd(16'h880, 8'h00, 8'h03, n);
        report(n == TS, "R12 sector wins duration", n, TS);
        rd_mem(16'h880, 8'hFF, "R12 sector wins data");

        // R12 zero command keeps unlock
        set_adr(16'h881);
        wr(A_WDAT, 8'h3C);
        unlock();
        wr(A_CMD, 8'h00);
        rd(A_STAT, 8'h00, "R12 zero no start");
        rd(A_ERR, 8'h00, "R12 zero no error");
        wr(A_CMD, 8'h01);
        busy_len(n);
        report(n == TP, "R12 unlock kept", n, TP);
        rd_mem(16'h881, 8'h3C, "R12 program after zero");

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule